// File: doc/BRIEF.md
# DRAM Page-Hit Traffic Address Generator

This block produces a stream of memory request descriptors (byte address, read or write flag, transfer size) meant to load a DRAM controller with a known pattern. Requests come in runs. Every request in a run is one block long, and all requests of a run fall into one page of one bank. The stride setting controls how many requests make up a run. The number of banks the run may pick from and the way bank and column fields sit in the address are also set by configuration. Together these control how many page hits follow each other and how widely the traffic spreads across banks.

At the start of each run the block draws four things from a seeded pseudo-random source: the transfer direction, a block-aligned base address inside a configured window, a bank and a starting column. It writes the bank and column into the base address at the bit positions that the selected mapping defines. The later requests of the run step to the next column. Requests leave through a registered valid/ready port. A byte counter totals the data moved by accepted requests.

Top module: `dram_traffic_gen`

## Requirements
- R1: The run length n is 1 when cfg_stride <= 64. Otherwise n is ceil(cfg_stride/64), capped at 32. Direction, row and bank stay fixed within a run. Each later request of a run targets the next column: +64 bytes under the column-low mapping, +512 bytes under the bank-low mapping.
- R2: Direction is decided once per run from the random word R. A cfg_read_pct of 0 gives a write (req_read=0). A value of 100 or more gives a read. Any other value gives a read exactly when R mod 101 is below cfg_read_pct.
- R3: The random word R starts at SEED (default 0x1ACEB00C) after reset. The first request of each run uses the current R, and R then advances one step: shift right by one, and if the bit shifted out was 1, XOR with 0x80200003. R never becomes zero.
- R4: The base address is cfg_start_addr + (R mod (cfg_end_addr - cfg_start_addr)), or cfg_start_addr if cfg_end_addr <= cfg_start_addr. It is then rounded down to a multiple of 64. Every request address is 64-byte aligned.
- R5: The bank is (R[31:16]) mod cfg_banks_used. The starting column is (R[31:8]) mod (32 - n + 1), so all n columns of the run fit inside one 32-column page.
- R6: cfg_map_sel = 0 selects bank-low: bank in address bits [8:6], column in bits [13:9]. Any other value selects column-low: column in bits [10:6], bank in bits [13:11]. All other address bits come from the base. The mapping is latched at run start.
- R7: A presented request keeps its address and direction until it is accepted (req_valid and req_ready high at a clock edge). When en is high, the next request appears in the cycle after acceptance.
- R8: bytes_total starts at 0 and grows by 64 for every accepted request.
- R9: cfg_banks_used of 0 or above 8 is a configuration error. cfg_err goes high one cycle later, and no new run starts. A run already in progress still completes.
- R10: After reset, req_valid, bytes_total and cfg_err are all 0.
- R11: With en low, no new request is loaded. req_valid drops once the presented request is accepted. When en goes high again, the interrupted run resumes at its next column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new requests to be loaded |
| cfg_start_addr | input | ADDR_W | Lower bound of the address window |
| cfg_end_addr | input | ADDR_W | Upper bound (exclusive) of the address window |
| cfg_read_pct | input | 7 | Read percentage |
| cfg_stride | input | STRIDE_W | Bytes per run, sets run length |
| cfg_banks_used | input | KB+1 | Number of banks a run may pick from |
| cfg_map_sel | input | 2 | Address mapping selector |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | Consumer takes the request |
| req_addr | output | ADDR_W | Request byte address |
| req_read | output | 1 | 1 for read, 0 for write |
| req_size | output | BB+1 | Transfer size in bytes (block size) |
| bytes_total | output | CNT_W | Bytes moved by accepted requests |
| cfg_err | output | 1 | Bank count configuration is invalid |

## Verification
The reference model is exercised with several stride settings. A short stride gives single-request runs, a middle stride gives four-request runs, and an oversized stride gives a full-page run that must begin at column 0. Each run length exposes a different column range and step count. Both mappings, plus an out-of-range selector, are driven with the same stride, so a swap of the bank and column fields or a wrong step size shows up as a different address. Read percentages of 0, 50 and 100 separate the fixed-direction shortcuts from the random comparison. Randomly toggled ready, enable pauses in mid-run and bad bank counts applied before and during a run test holding, resumption and the rule that a started run always completes.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/dtg_lfsr.sv
module dtg_lfsr #(
  parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [31:0] state
);
  import dtg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (step) state <= lfsr_next(state);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != 32'd0); // R3
endmodule

// File: rtl/dtg_addr_map.sv
module dtg_addr_map #(
  parameter int ADDR_W = 32,
  parameter int BB     = 6,
  parameter int CB     = 5,
  parameter int KB     = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [KB-1:0]     bank,
  input  logic [CB-1:0]     col,
  input  logic              bank_low,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr = base;
    if (bank_low) begin
      addr[BB +: KB]      = bank;
      addr[BB+KB +: CB]   = col;
    end else begin
      addr[BB +: CB]      = col;
      addr[BB+CB +: KB]   = bank;
    end
  end
endmodule

// File: rtl/dram_traffic_gen.sv
module dram_traffic_gen #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int PAGE_BYTES  = 2048,
  parameter int TOTAL_BANKS = 8,
  parameter int STRIDE_W    = 16,
  parameter int CNT_W       = 32,
  parameter logic [31:0] SEED = 32'h1ACE_B00C,
  localparam int BB     = $clog2(BLOCK_BYTES),
  localparam int CB     = $clog2(PAGE_BYTES / BLOCK_BYTES),
  localparam int KB     = $clog2(TOTAL_BANKS),
  localparam int SIZE_W = BB + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [ADDR_W-1:0]   cfg_start_addr,
  input  logic [ADDR_W-1:0]   cfg_end_addr,
  input  logic [6:0]          cfg_read_pct,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [KB:0]         cfg_banks_used,
  input  logic [1:0]          cfg_map_sel,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                req_read,
  output logic [SIZE_W-1:0]   req_size,
  output logic [CNT_W-1:0]    bytes_total,
  output logic                cfg_err
);
  localparam int COLS = PAGE_BYTES / BLOCK_BYTES;

  logic [31:0]       rnd;
  logic              load, start_run, hs, cfg_bad;
  logic [CB:0]       remain_q, run_len, col_range;
  logic              map0_q;
  logic [STRIDE_W:0] stride_ceil;
  logic [31:0]       roll;
  logic              read_draw;
  logic [ADDR_W-1:0] span, offs, base_raw, base_blk, mapped_addr, step_addr;
  logic [15:0]       bank_mod;
  logic [23:0]       col_mod;
  logic [KB-1:0]     bank_draw;
  logic [CB-1:0]     col_draw;

  dtg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(start_run), .state(rnd)
  );

  assign cfg_bad = (cfg_banks_used == '0) || (32'(cfg_banks_used) > TOTAL_BANKS);

  // run length from stride, capped at one page of columns
  assign stride_ceil = ({1'b0, cfg_stride} + (STRIDE_W+1)'(BLOCK_BYTES - 1)) >> BB;
  always_comb begin
    if (cfg_stride <= STRIDE_W'(BLOCK_BYTES)) run_len = (CB+1)'(1);
    else if (stride_ceil >= (STRIDE_W+1)'(COLS)) run_len = (CB+1)'(COLS);
    else run_len = stride_ceil[CB:0];
  end

  // direction draw
  assign roll = rnd % 32'd101;
  always_comb begin
    if (cfg_read_pct == 7'd0) read_draw = 1'b0;
    else if (cfg_read_pct >= 7'd100) read_draw = 1'b1;
    else read_draw = (roll < 32'(cfg_read_pct));
  end

  // base address draw
  assign span     = cfg_end_addr - cfg_start_addr;
  assign offs     = ADDR_W'(rnd) % span;
  assign base_raw = (cfg_end_addr > cfg_start_addr) ? cfg_start_addr + offs : cfg_start_addr;
  assign base_blk = {base_raw[ADDR_W-1:BB], {BB{1'b0}}};

  // bank and column draws
  assign bank_mod  = rnd[31:16] % 16'(cfg_banks_used);
  assign bank_draw = bank_mod[KB-1:0];
  assign col_range = (CB+1)'(COLS) - run_len + (CB+1)'(1);
  assign col_mod   = rnd[31:8] % 24'(col_range);
  assign col_draw  = col_mod[CB-1:0];

  dtg_addr_map #(.ADDR_W(ADDR_W), .BB(BB), .CB(CB), .KB(KB)) u_map (
    .base(base_blk), .bank(bank_draw), .col(col_draw),
    .bank_low(cfg_map_sel == 2'd0), .addr(mapped_addr)
  );

  // next column inside the run
  assign step_addr = map0_q ? req_addr + (ADDR_W'(BLOCK_BYTES) << KB)
                            : req_addr + ADDR_W'(BLOCK_BYTES);

  assign hs        = req_valid && req_ready;
  assign load      = en && (!req_valid || req_ready) && ((remain_q != '0) || !cfg_bad);
  assign start_run = load && (remain_q == '0);
  assign req_size  = SIZE_W'(BLOCK_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_read    <= 1'b0;
      remain_q    <= '0;
      map0_q      <= 1'b0;
      bytes_total <= '0;
      cfg_err     <= 1'b0;
    end else begin
      cfg_err <= cfg_bad;
      if (hs) bytes_total <= bytes_total + CNT_W'(BLOCK_BYTES);
      if (load) begin
        req_valid <= 1'b1;
        if (start_run) begin
          req_addr <= mapped_addr;
          req_read <= read_draw;
          remain_q <= run_len - (CB+1)'(1);
          map0_q   <= (cfg_map_sel == 2'd0);
        end else begin
          req_addr <= step_addr;
          remain_q <= remain_q - (CB+1)'(1);
        end
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  // assertion helpers: fields of the presented address under the latched mapping
  logic [ADDR_W-1:0] col_mask;
  logic [KB-1:0]     bank_field;
  assign col_mask   = ((ADDR_W'(1) << CB) - ADDR_W'(1)) << (map0_q ? BB + KB : BB);
  assign bank_field = map0_q ? req_addr[BB +: KB] : req_addr[BB+CB +: KB];

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_read)); // R7

  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[BB-1:0] == '0); // R4

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    load && !start_run |=> ((req_addr & ~col_mask) == $past(req_addr & ~col_mask)) && $stable(req_read)); // R1

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    start_run |=> 32'(bank_field) < $past(32'(cfg_banks_used))); // R5

  AST_BYTES_STEP: assert property (@(posedge clk) disable iff (rst)
    hs |=> bytes_total == $past(bytes_total) + CNT_W'(BLOCK_BYTES)); // R8
endmodule

// File: tb/tb_dram_traffic_gen.sv
module tb_dram_traffic_gen;
  logic        clk = 0, rst = 1, en = 0, req_ready = 1;
  logic [31:0] cfg_start_addr = 32'h1000, cfg_end_addr = 32'h10_0000;
  logic [6:0]  cfg_read_pct = 7'd50;
  logic [15:0] cfg_stride = 16'd200;
  logic [3:0]  cfg_banks_used = 4'd4;
  logic [1:0]  cfg_map_sel = 2'd1;
  logic        req_valid, req_read, cfg_err;
  logic [31:0] req_addr, bytes_total;
  logic [6:0]  req_size;

  dram_traffic_gen dut (
    .clk(clk), .rst(rst), .en(en),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_read_pct(cfg_read_pct), .cfg_stride(cfg_stride),
    .cfg_banks_used(cfg_banks_used), .cfg_map_sel(cfg_map_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_read(req_read), .req_size(req_size), .bytes_total(bytes_total),
    .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit cmp_en = 0, done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  longint m_lfsr = 32'h1ACE_B00C, m_addr = 0, m_bytes = 0;
  int     m_remain = 0;
  bit     m_valid = 0, m_read = 0, m_map0 = 0, m_err = 0;

  function automatic longint step_rnd(longint s);
    return (s % 2 == 1) ? ((s / 2) ^ 32'h8020_0003) : (s / 2);
  endfunction

  function automatic int run_n(int stride);
    int n;
    if (stride <= 64) return 1;
    n = (stride + 63) / 64;
    return (n > 32) ? 32 : n;
  endfunction

  always @(posedge clk) begin
    bit bad, ld, hs;
    longint r, base, bank, col, fld, span;
    int n;
    bad = (cfg_banks_used == 0) || (cfg_banks_used > 8);
    hs  = m_valid && req_ready;
    ld  = en && (!m_valid || req_ready) && (m_remain != 0 || !bad);
    if (rst) begin
      m_lfsr = 32'h1ACE_B00C; m_addr = 0; m_bytes = 0; m_remain = 0;
      m_valid = 0; m_read = 0; m_map0 = 0; m_err = 0;
    end else begin
      m_err = bad;
      if (hs) m_bytes = (m_bytes + 64) % 64'h1_0000_0000;
      if (ld) begin
        m_valid = 1;
        if (m_remain == 0) begin
          r = m_lfsr;
          m_lfsr = step_rnd(m_lfsr);
          n = run_n(cfg_stride);
          if (cfg_read_pct == 0) m_read = 0;
          else if (cfg_read_pct >= 100) m_read = 1;
          else m_read = (r % 101) < cfg_read_pct;
          span = longint'(cfg_end_addr) - longint'(cfg_start_addr);
          base = cfg_start_addr + ((span > 0) ? r % span : 0);
          base = base - base % 64;
          bank = (r / 65536) % cfg_banks_used;
          col  = (r / 256) % (32 - n + 1);
          fld  = (base / 64) % 256;
          m_map0 = (cfg_map_sel == 0);
          if (m_map0) m_addr = base - fld * 64 + (col * 8 + bank) * 64;
          else        m_addr = base - fld * 64 + (bank * 32 + col) * 64;
          m_remain = n - 1;
        end else begin
          m_addr = m_addr + (m_map0 ? 512 : 64);
          m_remain--;
        end
      end else if (req_ready) m_valid = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(req_valid == m_valid, "R7 valid vs model", req_valid, m_valid);
      if (m_valid) begin
        chk(req_addr == m_addr[31:0], "R3 R4 R5 R6 address vs model", req_addr, m_addr);
        chk(req_read == m_read, "R2 direction vs model", req_read, m_read);
      end
      chk(bytes_total == m_bytes[31:0], "R8 byte count vs model", bytes_total, m_bytes);
      chk(cfg_err == m_err, "R9 cfg_err vs model", cfg_err, m_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [31:0] cap_a [64];
  logic        cap_r [64];

  task automatic restart();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic capture(int k);
    int got = 0;
    while (got < k) begin
      @(negedge clk);
      if (req_valid && req_ready) begin
        cap_a[got] = req_addr; cap_r[got] = req_read; got++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(req_valid == 0, "R10 valid after reset", req_valid, 0);
    chk(bytes_total == 0, "R10 bytes after reset", bytes_total, 0);
    chk(cfg_err == 0, "R10 cfg_err after reset", cfg_err, 0);
    chk(req_size == 64, "R8 request size", req_size, 64);
    cmp_en = 1;

    // column-low mapping, four-request runs
    restart(); en = 1; capture(8); en = 0;
    for (int i = 1; i < 4; i++) begin
      chk(cap_a[i] == cap_a[0] + 64 * i, "R1 R6 column-low step", cap_a[i], cap_a[0] + 64 * i);
      chk(cap_r[i] == cap_r[0], "R1 direction held", cap_r[i], cap_r[0]);
    end
    chk(cap_a[0][5:0] == 0, "R4 alignment", cap_a[0][5:0], 0);
    chk(cap_a[0][13:11] < 4, "R5 bank below banks_used", cap_a[0][13:11], 3);
    chk(cap_a[0][10:6] <= 28, "R5 column leaves room for run", cap_a[0][10:6], 28);
    @(negedge clk);
    chk(req_valid == 0, "R11 valid drops with en low", req_valid, 0);
    chk(bytes_total == 512, "R8 bytes after eight", bytes_total, 512);

    // bank-low mapping
    cfg_map_sel = 0; cfg_banks_used = 8;
    restart(); en = 1; capture(4); en = 0;
    for (int i = 1; i < 4; i++)
      chk(cap_a[i] == cap_a[0] + 512 * i, "R6 bank-low column step", cap_a[i], cap_a[0] + 512 * i);

    // unknown selector acts as column-low
    cfg_map_sel = 3;
    restart(); en = 1; capture(2); en = 0;
    chk(cap_a[1] == cap_a[0] + 64, "R6 selector 3 as column-low", cap_a[1], cap_a[0] + 64);

    // full-page run
    cfg_map_sel = 1; cfg_stride = 5000;
    restart(); en = 1; capture(32); en = 0;
    chk(cap_a[0][10:6] == 0, "R1 R5 full run starts at column 0", cap_a[0][10:6], 0);
    chk(cap_a[31] == cap_a[0] + 31 * 64, "R1 full run last column", cap_a[31], cap_a[0] + 31 * 64);

    // single-request runs and direction extremes
    cfg_stride = 64; cfg_read_pct = 0;
    restart(); en = 1; capture(12); en = 0;
    cnt = 0; for (int i = 0; i < 12; i++) cnt += cap_r[i];
    chk(cnt == 0, "R2 pct 0 gives writes", cnt, 0);
    cfg_read_pct = 100;
    restart(); en = 1; capture(12); en = 0;
    cnt = 0; for (int i = 0; i < 12; i++) cnt += cap_r[i];
    chk(cnt == 12, "R2 pct 100 gives reads", cnt, 12);
    cfg_read_pct = 50; cfg_stride = 200;

    // backpressure
    restart(); req_ready = 0; en = 1;
    @(negedge clk); @(negedge clk);
    cap_a[0] = req_addr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == cap_a[0], "R7 held while not ready", req_addr, cap_a[0]);
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); req_ready = 1'($urandom % 2);
      if (i % 37 == 0) en = ~en;
    end
    req_ready = 1; en = 0;

    // bad bank count before any run
    cfg_banks_used = 0;
    restart(); en = 1;
    repeat (5) @(negedge clk);
    chk(req_valid == 0, "R9 no run with zero banks", req_valid, 0);
    chk(cfg_err == 1, "R9 cfg_err zero banks", cfg_err, 1);
    cfg_banks_used = 9;
    restart(); repeat (5) @(negedge clk);
    chk(req_valid == 0 && cfg_err == 1, "R9 no run with nine banks", req_valid, 0);

    // bad bank count in mid-run
    cfg_banks_used = 4; en = 0;
    restart(); en = 1; capture(1); cfg_banks_used = 9;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += req_valid; end
    chk(cnt == 3, "R9 started run completes", cnt, 3);
    en = 0; cfg_banks_used = 4;

    // pause and resume
    restart(); en = 1; capture(2); en = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req_valid == 0, "R11 nothing loaded while disabled", req_valid, 0);
    end
    en = 1; capture(1); en = 0;
    chk(cap_a[0] == cap_a[1] + 64, "R11 run resumes at next column", cap_a[0], cap_a[1] + 64);

    // empty window
    cfg_start_addr = 32'h5000_0ABC; cfg_end_addr = 32'h5000_0ABC; cfg_banks_used = 1; cfg_stride = 64;
    restart(); en = 1; capture(1); en = 0;
    chk(cap_a[0][31:14] == 18'(32'h5000_0ABC >> 14), "R4 empty window uses start", cap_a[0][31:14], 32'h5000_0ABC >> 14);
    chk(cap_a[0][13:11] == 0, "R5 single bank", cap_a[0][13:11], 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule